// File: doc/BRIEF.md
# Bypass-Write Invalidate Tracker with Launch Gate

This block sits beside a write path that stores straight into memory and never passes through the cache. Each such write is turned into a line invalidate for its address, sent toward the cache in the same cycle. The block then remembers that the invalidate is outstanding and records which requester (a small tag) is waiting on it. Several requesters may wait on one address. They share a single table slot, and each write still sends its own invalidate message.

When the cache reports that an address has been invalidated, every requester recorded under that address gets a response. The responses go out one per cycle, in the order the requesters were recorded. After the last one the slot becomes free. Completions that arrive for different addresses are answered in arrival order. A gate output tells the kernel-launch logic when it is safe to start. The gate is high only while nothing is outstanding and no response is still waiting to be sent. A launch request is granted only while the gate is high.

Top module: `bypass_inval_tracker`

## Requirements
- R1: An accepted write (`wr_valid` and `wr_ready` both high) drives `inv_valid` high and `inv_addr` equal to `wr_addr` in the same cycle. Without an accepted write, `inv_valid` is low.
- R2: After reset, `wr_ready` and `launch_ok` are high, and `rsp_valid`, `stray_err` and `inv_valid` are low.
- R3: A completion on `cmp_addr` for a waiting address answers every requester tag recorded under it. The first response is visible the cycle after the completion edge, and the rest follow one per cycle in recording order.
- R4: A slot is freed after its last response. A later completion for the same address is then treated as stray. A new write to that address starts a fresh list, and that list's completion returns only the new tags.
- R5: A write to an address that already has a waiting slot appends its tag to that slot and still raises `inv_valid` for its own address.
- R6: An address holds at most TAGS (default 4) requester tags. A further write to that address sees `wr_ready` low and sends no invalidate.
- R7: At most ENTRIES (default 8) addresses wait at once. When all slots are in use, a write to a new address sees `wr_ready` low. A write to an address that is already waiting and has room is still accepted.
- R8: A completion whose address has no waiting slot sets `stray_err`, which stays high until reset. It produces no response and leaves the waiting slots unchanged.
- R9: `launch_ok` is high exactly when no slot is waiting or draining. It is never high in a cycle where `rsp_valid` is high.
- R10: `launch_grant` is high only in a cycle where both `launch_req` and `launch_ok` are high. A held request is granted in the first cycle after the last response.
- R11: Completions for several addresses in consecutive cycles are answered in completion order. Each address's tags are sent in full before the next address's tags.
- R12: A write and a completion to the same waiting address in the same cycle are handled as one event: the write's tag is appended first and is answered by that completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | A bypassing write is presented |
| wr_addr | input | AW | Line address of the write |
| wr_tag | input | TW | Requester tag of the write |
| wr_ready | output | 1 | Write can be accepted this cycle |
| inv_valid | output | 1 | Invalidate message issued to the cache |
| inv_addr | output | AW | Address of the invalidate |
| cmp_valid | input | 1 | Invalidate completion from the cache |
| cmp_addr | input | AW | Address whose invalidate completed |
| rsp_valid | output | 1 | A requester response is presented |
| rsp_tag | output | TW | Tag of the requester being answered |
| stray_err | output | 1 | Sticky flag for an unmatched completion |
| launch_req | input | 1 | Kernel launch requested |
| launch_ok | output | 1 | Nothing outstanding, launch may proceed |
| launch_grant | output | 1 | Launch request granted this cycle |

## Verification
`wr_ready`, `inv_valid`, `inv_addr`, `launch_ok` and `launch_grant` are combinational. The bench checks them 1 ns after it drives inputs on the falling edge, which is before the rising edge that accepts the write. Responses come from registers. The first response is due in the cycle after the completion edge, and the bench checks it on the next falling edge. A monitor records every response seen on a falling edge, so the order and count can be compared once the drain is finished. `stray_err` and `launch_ok` are checked just after the rising edge that changes them. The launch grant is checked cycle by cycle so that it appears exactly one cycle after the last response.

// File: rtl/inv_track_pkg.sv
package inv_track_pkg;

    typedef enum logic [1:0] {
        SLOT_FREE  = 2'd0,
        SLOT_WAIT  = 2'd1,
        SLOT_DRAIN = 2'd2
    } slot_state_e;

    function automatic int unsigned idx_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/inv_pick.sv
module inv_pick #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        any = |req;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/inv_order_fifo.sv
module inv_order_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW = inv_track_pkg::idx_bits(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [PW:0]   cnt;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign dout  = mem[rp];
    assign empty = (cnt == '0);
    assign full  = (cnt == (PW+1)'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= bump(wp);
            if (pop)  rp <= bump(rp);
            if (push && !pop)      cnt <= cnt + 1'b1;
            else if (!push && pop) cnt <= cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    a_r11_no_overflow: assert property (@(posedge clk) disable iff (rst)
        push |-> (!full || pop));
    a_r11_no_underflow: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);
endmodule

// File: rtl/inv_slot.sv
module inv_slot #(
    parameter int AW   = 32,
    parameter int TW   = 6,
    parameter int TAGS = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          alloc,
    input  logic          append,
    input  logic          complete,
    input  logic          advance,
    input  logic [AW-1:0] in_addr,
    input  logic [TW-1:0] in_tag,
    output logic          waiting,
    output logic          draining,
    output logic          full,
    output logic          last,
    output logic [AW-1:0] addr_q,
    output logic [TW-1:0] head_tag
);
    import inv_track_pkg::*;

    localparam int RW = idx_bits(TAGS);
    localparam int CW = $clog2(TAGS + 1);

    slot_state_e   state;
    logic [TW-1:0] tags [TAGS];
    logic [CW-1:0] cnt;
    logic [RW-1:0] rd;

    assign waiting  = (state == SLOT_WAIT);
    assign draining = (state == SLOT_DRAIN);
    assign full     = (cnt == CW'(TAGS));
    assign last     = ((CW'(rd) + CW'(1)) == cnt);
    assign head_tag = tags[rd];

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SLOT_FREE;
            cnt    <= '0;
            rd     <= '0;
            addr_q <= '0;
        end else begin
            if (alloc) begin
                state  <= SLOT_WAIT;
                addr_q <= in_addr;
                cnt    <= CW'(1);
                rd     <= '0;
            end else if (append) begin
                cnt <= cnt + CW'(1);
            end
            if (complete) state <= SLOT_DRAIN;
            if (advance) begin
                if (last) begin
                    state <= SLOT_FREE;
                    cnt   <= '0;
                    rd    <= '0;
                end else begin
                    rd <= rd + RW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (alloc)       tags[0]           <= in_tag;
        else if (append) tags[RW'(cnt)]    <= in_tag;
    end

    a_r6_append_room: assert property (@(posedge clk) disable iff (rst)
        append |-> !full);
    a_r4_alloc_free: assert property (@(posedge clk) disable iff (rst)
        alloc |-> (state == SLOT_FREE));
    a_r3_advance_drain: assert property (@(posedge clk) disable iff (rst)
        advance |-> (state == SLOT_DRAIN));
    a_r3_complete_waiting: assert property (@(posedge clk) disable iff (rst)
        complete |-> (state == SLOT_WAIT));
endmodule

// File: rtl/bypass_inval_tracker.sv
module bypass_inval_tracker #(
    parameter int AW      = 32,
    parameter int TW      = 6,
    parameter int ENTRIES = 8,
    parameter int TAGS    = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_valid,
    input  logic [AW-1:0] wr_addr,
    input  logic [TW-1:0] wr_tag,
    output logic          wr_ready,
    output logic          inv_valid,
    output logic [AW-1:0] inv_addr,
    input  logic          cmp_valid,
    input  logic [AW-1:0] cmp_addr,
    output logic          rsp_valid,
    output logic [TW-1:0] rsp_tag,
    output logic          stray_err,
    input  logic          launch_req,
    output logic          launch_ok,
    output logic          launch_grant
);
    localparam int IW = inv_track_pkg::idx_bits(ENTRIES);

    logic [ENTRIES-1:0] wait_v, drain_v, full_v, last_v;
    logic [ENTRIES-1:0] wr_hit_v, cmp_hit_v, free_v;
    logic [ENTRIES-1:0] alloc_v, append_v, advance_v;
    logic [AW-1:0]      s_addr [ENTRIES];
    logic [TW-1:0]      s_tag  [ENTRIES];

    logic          wr_hit, hit_full, free_any, cmp_any, accept;
    logic [IW-1:0] free_idx, cmp_idx, head_idx, unused_hit_idx;
    logic          fifo_empty, fifo_full, fifo_pop;

    assign free_v   = ~(wait_v | drain_v);
    assign wr_hit   = |wr_hit_v;
    assign hit_full = |(wr_hit_v & full_v);
    assign wr_ready = wr_hit ? !hit_full : free_any;
    assign accept   = wr_valid && wr_ready;

    assign inv_valid = accept;
    assign inv_addr  = wr_addr;

    inv_pick #(.N(ENTRIES), .IW(IW)) u_free_pick (
        .req(free_v), .idx(free_idx), .any(free_any));

    inv_pick #(.N(ENTRIES), .IW(IW)) u_cmp_enc (
        .req(cmp_hit_v), .idx(cmp_idx), .any(cmp_any));

    inv_pick #(.N(ENTRIES), .IW(IW)) u_hit_enc (
        .req(wr_hit_v), .idx(unused_hit_idx), .any());

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        assign wr_hit_v[g]  = wait_v[g] && (s_addr[g] == wr_addr);
        assign cmp_hit_v[g] = cmp_valid && wait_v[g] && (s_addr[g] == cmp_addr);
        assign alloc_v[g]   = accept && !wr_hit && free_v[g] && (free_idx == IW'(g));
        assign append_v[g]  = accept && wr_hit_v[g];
        assign advance_v[g] = !fifo_empty && (head_idx == IW'(g));

        inv_slot #(.AW(AW), .TW(TW), .TAGS(TAGS)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .alloc    (alloc_v[g]),
            .append   (append_v[g]),
            .complete (cmp_hit_v[g]),
            .advance  (advance_v[g]),
            .in_addr  (wr_addr),
            .in_tag   (wr_tag),
            .waiting  (wait_v[g]),
            .draining (drain_v[g]),
            .full     (full_v[g]),
            .last     (last_v[g]),
            .addr_q   (s_addr[g]),
            .head_tag (s_tag[g])
        );
    end

    inv_order_fifo #(.DEPTH(ENTRIES), .W(IW)) u_order (
        .clk   (clk),
        .rst   (rst),
        .push  (cmp_any),
        .din   (cmp_idx),
        .pop   (fifo_pop),
        .dout  (head_idx),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    assign rsp_valid = !fifo_empty;
    assign rsp_tag   = s_tag[head_idx];
    assign fifo_pop  = rsp_valid && last_v[head_idx];

    always_ff @(posedge clk) begin
        if (rst)                       stray_err <= 1'b0;
        else if (cmp_valid && !cmp_any) stray_err <= 1'b1;
    end

    assign launch_ok    = !(|(wait_v | drain_v));
    assign launch_grant = launch_req && launch_ok;

    a_r8_sticky_err: assert property (@(posedge clk) disable iff (rst)
        stray_err |=> stray_err);
    a_r9_no_launch_while_rsp: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !launch_ok);
    a_r7_single_alloc: assert property (@(posedge clk) disable iff (rst)
        $onehot0(alloc_v));
    a_r5_single_match: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_hit_v));
    a_r11_order_room: assert property (@(posedge clk) disable iff (rst)
        cmp_any |-> (!fifo_full || fifo_pop));
endmodule

// File: tb/bypass_inval_tracker_test.sv
module bypass_inval_tracker_test;
    localparam int AW = 32;
    localparam int TW = 6;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst = 1'b1;
    logic          wr_valid = 1'b0, cmp_valid = 1'b0, launch_req = 1'b0;
    logic [AW-1:0] wr_addr = '0, cmp_addr = '0;
    logic [TW-1:0] wr_tag = '0;
    logic          wr_ready, inv_valid, rsp_valid, stray_err, launch_ok, launch_grant;
    logic [AW-1:0] inv_addr;
    logic [TW-1:0] rsp_tag;

    bypass_inval_tracker uut (
        .clk(clk), .rst(rst),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_tag(wr_tag), .wr_ready(wr_ready),
        .inv_valid(inv_valid), .inv_addr(inv_addr),
        .cmp_valid(cmp_valid), .cmp_addr(cmp_addr),
        .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .stray_err(stray_err),
        .launch_req(launch_req), .launch_ok(launch_ok), .launch_grant(launch_grant)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [TW-1:0] got [64];
    int            got_n   = 0;
    int            overlap = 0;
    logic [TW-1:0] exp_t [16];

    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (got_n < 64) got[got_n] = rsp_tag;
            got_n = got_n + 1;
            if (launch_ok) overlap = overlap + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic step(input bit wv, input logic [AW-1:0] wa, input logic [TW-1:0] wt,
                        input bit cv, input logic [AW-1:0] ca, input bit exp_rdy,
                        input string req);
        @(negedge clk);
        wr_valid = wv; wr_addr = wa; wr_tag = wt;
        cmp_valid = cv; cmp_addr = ca;
        #1;
        if (wv) begin
            chk(wr_ready == exp_rdy, req, "wr_ready", wr_ready, exp_rdy);
            chk(inv_valid == exp_rdy, req, "inv_valid", inv_valid, exp_rdy);
            if (exp_rdy) chk(inv_addr == wa, req, "inv_addr", inv_addr, wa);
        end
        @(posedge clk);
        #1;
        wr_valid = 1'b0; cmp_valid = 1'b0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [TW-1:0] t, input string req);
        step(1'b1, a, t, 1'b0, '0, 1'b1, req);
    endtask

    task automatic cmpl(input logic [AW-1:0] a);
        step(1'b0, '0, '0, 1'b1, a, 1'b0, "");
    endtask

    task automatic expect_rsps(input int base, input int n, input string req);
        repeat (n + 2) @(posedge clk);
        #1;
        chk(got_n - base == n, req, "response count", got_n - base, n);
        for (int i = 0; i < n; i++)
            chk(got[base + i] == exp_t[i], req, "response tag", got[base + i], exp_t[i]);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    localparam logic [AW-1:0] VA [4] = '{32'h0000_0100, 32'h0000_2040, 32'hFFFF_FFC0, 32'h0000_0080};
    localparam int            VN [4] = '{1, 3, 4, 2};

    initial begin
        int base;
        do_reset();
        @(negedge clk); #1;
        chk(wr_ready == 1'b1, "R2", "wr_ready", wr_ready, 1);
        chk(launch_ok == 1'b1, "R2", "launch_ok", launch_ok, 1);
        chk(rsp_valid == 1'b0, "R2", "rsp_valid", rsp_valid, 0);
        chk(stray_err == 1'b0, "R2", "stray_err", stray_err, 0);
        chk(inv_valid == 1'b0, "R1", "inv_valid idle", inv_valid, 0);

        // Vector table: groups of writes to one address, then its completion
        for (int v = 0; v < 4; v++) begin
            for (int k = 0; k < VN[v]; k++) begin
                wr(VA[v], TW'(v * 4 + k), (k == 0) ? "R1" : "R5");
                exp_t[k] = TW'(v * 4 + k);
            end
            chk(launch_ok == 1'b0, "R9", "launch_ok pending", launch_ok, 0);
            base = got_n;
            cmpl(VA[v]);
            @(negedge clk); #1;
            chk(rsp_valid == 1'b1, "R3", "first rsp_valid", rsp_valid, 1);
            chk(rsp_tag == TW'(v * 4), "R3", "first rsp_tag", rsp_tag, v * 4);
            expect_rsps(base, VN[v], "R3");
            chk(launch_ok == 1'b1, "R9", "launch_ok drained", launch_ok, 1);
            chk(rsp_valid == 1'b0, "R3", "rsp_valid drained", rsp_valid, 0);
        end
        chk(overlap == 0, "R9", "launch_ok during rsp", overlap, 0);

        // R6: tag limit per address
        for (int k = 0; k < 4; k++) wr(32'hA000, TW'(10 + k), "R6");
        step(1'b1, 32'hA000, 6'd14, 1'b0, '0, 1'b0, "R6");
        wr(32'hB000, 6'd15, "R6");
        base = got_n;
        cmpl(32'hA000);
        for (int k = 0; k < 4; k++) exp_t[k] = TW'(10 + k);
        expect_rsps(base, 4, "R6");
        base = got_n;
        cmpl(32'hB000);
        exp_t[0] = 6'd15;
        expect_rsps(base, 1, "R6");

        // R7 / R11: full table, ordered completions
        for (int i = 0; i < 8; i++) wr(32'h1000 + AW'(i * 64), TW'(i), "R7");
        step(1'b1, 32'h9000, 6'd20, 1'b0, '0, 1'b0, "R7");
        wr(32'h1000, 6'd8, "R7");
        base = got_n;
        cmpl(32'h1000 + 3 * 64);
        cmpl(32'h1000);
        cmpl(32'h1000 + 5 * 64);
        exp_t[0] = 6'd3; exp_t[1] = 6'd0; exp_t[2] = 6'd8; exp_t[3] = 6'd5;
        expect_rsps(base, 4, "R11");
        base = got_n;
        cmpl(32'h1000 + 1 * 64); cmpl(32'h1000 + 2 * 64); cmpl(32'h1000 + 4 * 64);
        cmpl(32'h1000 + 6 * 64); cmpl(32'h1000 + 7 * 64);
        exp_t[0] = 6'd1; exp_t[1] = 6'd2; exp_t[2] = 6'd4; exp_t[3] = 6'd6; exp_t[4] = 6'd7;
        expect_rsps(base, 5, "R11");
        chk(launch_ok == 1'b1, "R9", "launch_ok after table drain", launch_ok, 1);

        // R12: simultaneous append and completion
        wr(32'h300, 6'd21, "R12");
        base = got_n;
        step(1'b1, 32'h300, 6'd22, 1'b1, 32'h300, 1'b1, "R12");
        exp_t[0] = 6'd21; exp_t[1] = 6'd22;
        expect_rsps(base, 2, "R12");

        // R10: held launch request
        wr(32'h400, 6'd23, "R10");
        wr(32'h400, 6'd24, "R10");
        launch_req = 1'b1;
        @(negedge clk); #1;
        chk(launch_grant == 1'b0, "R10", "grant while pending", launch_grant, 0);
        cmpl(32'h400);
        @(negedge clk); #1;
        chk(launch_grant == 1'b0, "R10", "grant rsp1", launch_grant, 0);
        @(negedge clk); #1;
        chk(launch_grant == 1'b0, "R10", "grant rsp2", launch_grant, 0);
        @(negedge clk); #1;
        chk(launch_grant == 1'b1, "R10", "grant after drain", launch_grant, 1);
        launch_req = 1'b0;
        #1;
        chk(launch_grant == 1'b0, "R10", "grant without req", launch_grant, 0);

        // R4 / R8: freed slot, stray completions
        wr(32'h500, 6'd25, "R4");
        cmpl(32'h500);
        repeat (4) @(posedge clk); #1;
        chk(stray_err == 1'b0, "R8", "no stray yet", stray_err, 0);
        base = got_n;
        cmpl(32'h500);
        chk(stray_err == 1'b1, "R4", "stray after free", stray_err, 1);
        repeat (4) @(posedge clk); #1;
        chk(got_n == base, "R4", "no rsp for freed", got_n - base, 0);
        wr(32'h500, 6'd26, "R4");
        wr(32'h600, 6'd27, "R8");
        base = got_n;
        cmpl(32'h700);
        repeat (3) @(posedge clk); #1;
        chk(got_n == base, "R8", "no rsp for stray", got_n - base, 0);
        chk(launch_ok == 1'b0, "R8", "table kept", launch_ok, 0);
        cmpl(32'h500);
        exp_t[0] = 6'd26;
        expect_rsps(base, 1, "R4");
        base = got_n;
        cmpl(32'h600);
        exp_t[0] = 6'd27;
        expect_rsps(base, 1, "R8");
        chk(stray_err == 1'b1, "R8", "sticky", stray_err, 1);

        do_reset();
        #1;
        chk(stray_err == 1'b0, "R2", "stray_err cleared", stray_err, 0);
        chk(launch_ok == 1'b1, "R2", "launch_ok after reset", launch_ok, 1);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule